// File: doc/BRIEF.md
# Segmented Triggered Event Buffer

This block runs a sample memory as a ring of equal event segments. While acquisition runs, every valid sample is written into the active segment, and the write offset wraps around inside that segment. The segment therefore always holds the most recent window of samples.

When a trigger is accepted, the block does four things:
- It stores the value of a free-running 32-bit time tag.
- It gives the event the next number.
- It records the offset where the first post-trigger sample will land.
- It writes a programmable number of further samples.

The segment is then frozen for readout, and writing moves on to offset zero of the next segment in the following cycle, with no gap in the stream.

Frozen segments wait in arrival order. The oldest one is shown on the readout outputs until a readout-done pulse returns it to the free pool. A single organization code, captured while reset is held, splits the memory into 2^N segments. When every segment is frozen, the block raises a full flag. It then stops writing and ignores triggers until a segment is released.

Top module: `sebuf_ctrl`

## Requirements
- R1: An organization code N (held on `org_code` while reset is low, and clamped to MAX_CODE if larger) gives 2^N segments of 2^(ADDR_W-N) samples each. A sample at offset k of segment s goes to address s*2^(ADDR_W-N)+k.
- R2: A sample with `smp_valid` high in cycle t appears on the write port in cycle t+1. Offsets in the active segment rise by one per written sample and wrap from the last offset to 0. After reset the first write goes to address 0.
- R3: A 32-bit time tag is 0 after reset and increases by one every clock. An accepted trigger stores the value it holds in the trigger cycle, and that value shows on `rdy_ttt`.
- R4: Accepted triggers are numbered 1, 2, 3, ... from reset. The number appears on `rdy_evt` with its segment.
- R5: The sample written in the trigger cycle is the last pre-trigger sample. The next `post_cnt` written samples are post-trigger, and the segment freezes in the cycle its last post-trigger sample is written. With `post_cnt` = 0 it freezes in the trigger cycle. `rdy_trig_off` is the in-segment offset just after the trigger-cycle sample.
- R6: The first sample written after a freeze goes to offset 0 of the next segment, counting modulo the segment count, in the very next write cycle.
- R7: A trigger that arrives while post-trigger samples are still being written is ignored. It neither extends the window nor gets an event number.
- R8: While every segment is frozen, `full` is 1, no memory write occurs, and triggers are ignored and not numbered.
- R9: A `rd_done` pulse while `rdy_valid` is 1 releases the oldest frozen segment, in first-in first-out order. With `rdy_valid` at 0 the pulse has no effect. Writing resumes at offset 0 of a released segment.
- R10: After reset, `rdy_valid` is 0. While it is 1, `rdy_seg`, `rdy_trig_off`, `rdy_ttt` and `rdy_evt` describe the oldest frozen segment and stay stable until it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset; also captures `org_code` |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | DATA_W | Sample value |
| trig | input | 1 | Trigger request |
| org_code | input | CODE_W | Segment organization code |
| post_cnt | input | ADDR_W | Post-trigger sample count, read in the trigger cycle |
| rd_done | input | 1 | Release the oldest frozen segment |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| rdy_valid | output | 1 | At least one frozen segment waits |
| rdy_seg | output | MAX_CODE | Index of the oldest frozen segment |
| rdy_trig_off | output | ADDR_W | Offset of its first post-trigger sample |
| rdy_ttt | output | 32 | Its trigger time tag |
| rdy_evt | output | 32 | Its event number |
| full | output | 1 | All segments frozen |

## Verification
The bench targets the following corner cases and the failure each one would expose:

- **Offset wrap inside a segment (R2).** A counter that does not wrap would spill into the neighbouring segment.
- **Post-trigger boundary (R5).** An off-by-one freezes a cycle early or late, which moves the first write of the next segment and the recorded trigger offset.
- **`post_cnt` of zero (R5).** A design that handles this badly hangs in the post phase.
- **Second trigger inside the window (R7) and triggers while full (R8).** A design that restarts the window, or numbers these triggers, shows the wrong address after the freeze or the wrong event number after release.
- **Release with nothing frozen (R9).** A careless pointer would skip a segment.
- **Codes 0 and above the maximum (R1).** Unclamped geometry would put the next segment base at the wrong address.

// File: rtl/sebuf_pkg.sv
// Shared types for the segmented event buffer.
package sebuf_pkg;
    localparam int TAG_W = 32;

    // Per-event stamp kept with each frozen segment.
    typedef struct packed {
        logic [TAG_W-1:0] ttt;
        logic [TAG_W-1:0] evt;
    } stamp_t;
endpackage

// File: rtl/sebuf_geometry.sv
// Segment geometry decoder.
// Turns an organization code into a segment count, a mask for segment indices,
// a mask for in-segment offsets and the shift that places a segment base.
// Assumes ADDR_W > MAX_CODE and that code <= MAX_CODE (clamped upstream).
module sebuf_geometry #(
    parameter int ADDR_W   = 14,
    parameter int MAX_CODE = 10,
    parameter int CW       = 4,
    parameter int SH_W     = 4
) (
    input  logic [CW-1:0]       code,
    output logic [MAX_CODE:0]   nseg,
    output logic [MAX_CODE:0]   seg_mask,
    output logic [ADDR_W-1:0]   off_mask,
    output logic [SH_W-1:0]     shamt
);
    localparam int NW = MAX_CODE + 1;

    // Purpose: derive all geometry values from the code.
    always_comb begin
        nseg     = NW'(1) << code;
        seg_mask = nseg - 1'b1;
        shamt    = SH_W'(ADDR_W) - SH_W'(code);
        off_mask = (ADDR_W'(1) << shamt) - 1'b1;
    end
endmodule

// File: rtl/sebuf_tags.sv
// Time tag and event counter.
// The time tag advances every clock. The event count advances once per
// accepted trigger. Both wrap at 2^TAG_W.
module sebuf_tags
    import sebuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_evt,
    output logic [TAG_W-1:0] ttt,
    output logic [TAG_W-1:0] evt
);
    // Purpose: free-running time tag.
    always_ff @(posedge clk) begin
        if (!rst_n) ttt <= '0;
        else        ttt <= ttt + 1'b1;
    end

    // Purpose: count accepted triggers.
    always_ff @(posedge clk) begin
        if (!rst_n)       evt <= '0;
        else if (inc_evt) evt <= evt + 1'b1;
    end
endmodule

// File: rtl/sebuf_desc_store.sv
// Descriptor store, one entry per segment index.
// Written when a segment freezes and read combinationally for the oldest
// frozen segment. Assumes an entry is never written while it is being read
// out; the controller guarantees this.
module sebuf_desc_store
    import sebuf_pkg::*;
#(
    parameter int SEG_W = 10,
    parameter int OFF_W = 14
) (
    input  logic             clk,
    input  logic             we,
    input  logic [SEG_W-1:0] waddr,
    input  logic [OFF_W-1:0] woff,
    input  stamp_t           wstamp,
    input  logic [SEG_W-1:0] raddr,
    output logic [OFF_W-1:0] roff,
    output stamp_t           rstamp
);
    localparam int DEPTH = 1 << SEG_W;
    localparam int W     = OFF_W + $bits(stamp_t);

    logic [W-1:0] mem [DEPTH];

    // Purpose: record the descriptor of a freezing segment.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= {woff, wstamp};
    end

    // Purpose: present the descriptor of the requested segment.
    always_comb begin
        {roff, rstamp} = mem[raddr];
    end
endmodule

// File: rtl/sebuf_ctrl.sv
// Segmented triggered event buffer controller (top).
// Writes samples into a ring of segments. On an accepted trigger it captures a
// stamp, writes post_cnt more samples, freezes the segment and moves on to the
// next one. Frozen segments are released first-in first-out by rd_done.
// Assumes: org_code is steady while rst_n is low; ADDR_W > MAX_CODE >= 1;
// CODE_W >= clog2(MAX_CODE+1).
module sebuf_ctrl
    import sebuf_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int DATA_W   = 14,
    parameter int MAX_CODE = 10,
    parameter int CODE_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [DATA_W-1:0]   smp_data,
    input  logic                trig,
    input  logic [CODE_W-1:0]   org_code,
    input  logic [ADDR_W-1:0]   post_cnt,
    input  logic                rd_done,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                rdy_valid,
    output logic [MAX_CODE-1:0] rdy_seg,
    output logic [ADDR_W-1:0]   rdy_trig_off,
    output logic [TAG_W-1:0]    rdy_ttt,
    output logic [TAG_W-1:0]    rdy_evt,
    output logic                full
);
    localparam int SEG_W = MAX_CODE;
    localparam int NW    = MAX_CODE + 1;
    localparam int CW    = $clog2(MAX_CODE + 1);
    localparam int SH_W  = $clog2(ADDR_W + 1);
    localparam logic [CODE_W-1:0] MAXC = CODE_W'(MAX_CODE);

    logic [CW-1:0]     code_r, code_sat;
    logic [NW-1:0]     nseg, seg_mask;
    logic [ADDR_W-1:0] off_mask;
    logic [SH_W-1:0]   shamt;

    logic [SEG_W-1:0]  head, act_seg;
    logic [NW-1:0]     fc;
    logic [ADDR_W-1:0] wptr, wnext, wpos, rem, pend_off, desc_off, wr_addr;
    logic              post_r, wr, accept, freeze, rel, full_i;
    logic [TAG_W-1:0]  ttt, evt;
    stamp_t            pend_stamp, new_stamp, desc_stamp, rd_stamp;

    sebuf_geometry #(
        .ADDR_W(ADDR_W), .MAX_CODE(MAX_CODE), .CW(CW), .SH_W(SH_W)
    ) u_geom (
        .code(code_r), .nseg(nseg), .seg_mask(seg_mask),
        .off_mask(off_mask), .shamt(shamt)
    );

    sebuf_tags u_tags (
        .clk(clk), .rst_n(rst_n), .inc_evt(accept), .ttt(ttt), .evt(evt)
    );

    sebuf_desc_store #(.SEG_W(SEG_W), .OFF_W(ADDR_W)) u_store (
        .clk(clk), .we(freeze), .waddr(act_seg), .woff(desc_off),
        .wstamp(desc_stamp), .raddr(head), .roff(rdy_trig_off), .rstamp(rd_stamp)
    );

    // Purpose: clamp the requested organization code to the supported range.
    always_comb begin
        code_sat = (org_code > MAXC) ? CW'(MAX_CODE) : org_code[CW-1:0];
    end

    // Purpose: decide this cycle's write, trigger acceptance, freeze and release.
    always_comb begin
        full_i     = (fc == nseg);
        act_seg    = SEG_W'((NW'(head) + fc) & seg_mask);
        wr         = smp_valid && !full_i;
        accept     = trig && !full_i && !post_r;
        wnext      = (wptr + 1'b1) & off_mask;
        wpos       = wr ? wnext : wptr;
        freeze     = (accept && (post_cnt == '0)) ||
                     (post_r && wr && (rem == ADDR_W'(1)));
        rel        = rd_done && (fc != '0);
        new_stamp  = '{ttt: ttt, evt: evt + 1'b1};
        desc_off   = accept ? wpos : pend_off;
        desc_stamp = accept ? new_stamp : pend_stamp;
        wr_addr    = (ADDR_W'(act_seg) << shamt) | (wptr & off_mask);
    end

    // Purpose: segment ring pointers, write offset and post-trigger phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_r <= code_sat;
            head   <= '0;
            fc     <= '0;
            wptr   <= '0;
            post_r <= 1'b0;
            rem    <= '0;
        end else begin
            wptr <= freeze ? '0 : wpos;
            if (rel) head <= SEG_W'((NW'(head) + 1'b1) & seg_mask);
            case ({freeze, rel})
                2'b10:   fc <= fc + 1'b1;
                2'b01:   fc <= fc - 1'b1;
                default: fc <= fc;
            endcase
            if (freeze) begin
                post_r <= 1'b0;
                rem    <= '0;
            end else if (accept) begin
                post_r <= 1'b1;
                rem    <= post_cnt;
            end else if (post_r && wr) begin
                rem    <= rem - 1'b1;
            end
        end
    end

    // Purpose: hold the stamp of the event in its post-trigger phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_off   <= '0;
            pend_stamp <= '0;
        end else if (accept) begin
            pend_off   <= wpos;
            pend_stamp <= new_stamp;
        end
    end

    // Purpose: registered memory write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= wr;
            if (wr) begin
                mem_addr  <= wr_addr;
                mem_wdata <= smp_data;
            end
        end
    end

    // Purpose: readout view of the oldest frozen segment.
    always_comb begin
        rdy_valid = (fc != '0);
        rdy_seg   = head;
        rdy_ttt   = rd_stamp.ttt;
        rdy_evt   = rd_stamp.evt;
        full      = full_i;
    end
endmodule

// File: rtl/sebuf_ctrl_chk.sv
// Property checker for sebuf_ctrl, attached by bind.
// Assumes it is connected to the top-level ports and to the post-phase state.
module sebuf_ctrl_chk #(
    parameter int ADDR_W = 14,
    parameter int SEG_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              full,
    input logic              mem_we,
    input logic              rd_done,
    input logic              rdy_valid,
    input logic [SEG_W-1:0]  rdy_seg,
    input logic [31:0]       rdy_ttt,
    input logic [31:0]       rdy_evt,
    input logic              post_r,
    input logic [ADDR_W-1:0] rem
);
    assert_full_halts_writes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> !mem_we);

    assert_full_has_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> rdy_valid);

    assert_event_numbered_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_valid |-> (rdy_evt != 32'd0));

    assert_post_count_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
        post_r |-> (rem != '0));

    assert_head_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_valid && $past(rdy_valid) && !$past(rd_done)) |->
            ($stable(rdy_seg) && $stable(rdy_ttt) && $stable(rdy_evt)));
endmodule

bind sebuf_ctrl sebuf_ctrl_chk #(.ADDR_W(ADDR_W), .SEG_W(MAX_CODE)) u_chk (
    .clk(clk), .rst_n(rst_n), .full(full), .mem_we(mem_we), .rd_done(rd_done),
    .rdy_valid(rdy_valid), .rdy_seg(rdy_seg), .rdy_ttt(rdy_ttt),
    .rdy_evt(rdy_evt), .post_r(post_r), .rem(rem)
);

// File: tb/sebuf_ctrl_tb.sv
// Directed bench for sebuf_ctrl: one task per scenario.
module sebuf_ctrl_tb;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 12;
    localparam int MAX_CODE = 4;
    localparam int CODE_W   = 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                smp_valid = 1'b0;
    logic [DATA_W-1:0]   smp_data = '0;
    logic                trig = 1'b0;
    logic [CODE_W-1:0]   org_code = '0;
    logic [ADDR_W-1:0]   post_cnt = '0;
    logic                rd_done = 1'b0;
    logic                mem_we;
    logic [ADDR_W-1:0]   mem_addr;
    logic [DATA_W-1:0]   mem_wdata;
    logic                rdy_valid;
    logic [MAX_CODE-1:0] rdy_seg;
    logic [ADDR_W-1:0]   rdy_trig_off;
    logic [31:0]         rdy_ttt;
    logic [31:0]         rdy_evt;
    logic                full;

    int          n_chk = 0;
    int          n_err = 0;
    logic [31:0] cyc = '0;

    sebuf_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_CODE(MAX_CODE), .CODE_W(CODE_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .trig(trig), .org_code(org_code), .post_cnt(post_cnt), .rd_done(rd_done),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .rdy_valid(rdy_valid), .rdy_seg(rdy_seg), .rdy_trig_off(rdy_trig_off),
        .rdy_ttt(rdy_ttt), .rdy_evt(rdy_evt), .full(full)
    );

    always #4 clk = ~clk;

    // Independent cycle count since reset release, used for time tag checks.
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 32'd0;

    always @(posedge clk) smp_data <= smp_data + 1'b1;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [CODE_W-1:0] code);
        @(negedge clk);
        rst_n = 1'b0; org_code = code; smp_valid = 1'b0;
        trig = 1'b0; rd_done = 1'b0; post_cnt = '0;
        step(2);
        rst_n = 1'b1; smp_valid = 1'b1;
    endtask

    task automatic fire(input int post);
        trig = 1'b1; post_cnt = ADDR_W'(post);
        step(1);
        trig = 1'b0;
        step(post);
    endtask

    task automatic release_one();
        rd_done = 1'b1;
        step(1);
        rd_done = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(4'd2);
        check("R2 no write after reset", mem_we, 0);
        check("R10 nothing ready after reset", rdy_valid, 0);
        check("R8 not full after reset", full, 0);
    endtask

    task automatic t_wrap_and_idle_release();
        do_reset(4'd4);                       // 16 segments of 16
        step(20);
        check("R2 writing", mem_we, 1);
        check("R2 offset wraps in segment", mem_addr, 3);
        release_one();                        // nothing frozen: ignored (R9)
        fire(1);
        check("R9 idle release ignored, head", rdy_seg, 0);
        check("R4 first event number", rdy_evt, 1);
        step(1);
        check("R1 next segment base code 4", mem_addr, 16);
    endtask

    task automatic t_event();
        logic [ADDR_W-1:0] obs;
        logic [31:0]       exp_t;
        do_reset(4'd2);                       // 4 segments of 64
        step(10);
        obs = mem_addr;
        exp_t = cyc;
        trig = 1'b1; post_cnt = 8'd5;
        step(1);
        trig = 1'b0;
        step(4);
        check("R5 not frozen before last post sample", rdy_valid, 0);
        step(1);
        check("R5 frozen after post samples", rdy_valid, 1);
        check("R10 oldest segment", rdy_seg, 0);
        check("R3 time tag", rdy_ttt, exp_t);
        check("R4 event number", rdy_evt, 1);
        check("R5 trigger offset", rdy_trig_off, (obs + 8'd2) & 8'd63);
        check("R5 last post sample offset", mem_addr, (obs + 8'd6) & 8'd63);
        step(1);
        check("R6 next segment starts at base", mem_addr, 64);
    endtask

    task automatic t_ignore_in_post();
        do_reset(4'd2);
        step(3);
        fire(2);
        trig = 1'b1; post_cnt = 8'd4;
        step(1);                              // accepted
        step(1);                              // still high: must be ignored
        trig = 1'b0;
        step(3);
        step(1);
        check("R7 window not extended", mem_addr, 128);
        release_one();
        check("R9 fifo order", rdy_seg, 1);
        check("R7 ignored trigger not numbered", rdy_evt, 2);
    endtask

    task automatic t_full();
        do_reset(4'd1);                       // 2 segments of 128
        step(3);
        fire(2);
        check("R8 one free segment left", full, 0);
        fire(2);
        check("R8 full flag", full, 1);
        step(1);
        check("R8 writes stop", mem_we, 0);
        fire(1);                              // ignored while full
        step(1);
        check("R8 still no writes", mem_we, 0);
        release_one();
        check("R9 full clears", full, 0);
        check("R9 next oldest", rdy_seg, 1);
        check("R9 next event", rdy_evt, 2);
        step(1);
        check("R9 writes resume", mem_we, 1);
        check("R9 resume at released base", mem_addr, 0);
        fire(1);
        release_one();
        check("R9 wrap to segment 0", rdy_seg, 0);
        check("R8 trigger while full not numbered", rdy_evt, 3);
    endtask

    task automatic t_code_limits();
        do_reset(4'd7);                       // clamps to 4
        step(2);
        fire(1);
        step(1);
        check("R1 code clamped to maximum", mem_addr, 16);
        do_reset(4'd0);                       // single segment
        step(2);
        fire(1);
        check("R1 code 0 single segment full", full, 1);
    endtask

    task automatic t_post_zero();
        logic [ADDR_W-1:0] obs;
        do_reset(4'd3);                       // 8 segments of 32
        step(5);
        obs = mem_addr;
        check("R5 idle before trigger", rdy_valid, 0);
        trig = 1'b1; post_cnt = '0;
        step(1);
        trig = 1'b0;
        check("R5 zero post freezes at once", rdy_valid, 1);
        check("R5 zero post offset", rdy_trig_off, (obs + 8'd2) & 8'd31);
        check("R5 trigger sample in old segment", mem_addr, obs + 8'd1);
        step(1);
        check("R6 next segment after zero post", mem_addr, 32);
    endtask

    initial begin
        #(8 * 100000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_wrap_and_idle_release();
        t_event();
        t_ignore_in_post();
        t_full();
        t_code_limits();
        t_post_zero();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule